// File: doc/BRIEF.md
# Low-Side Switch Fault Latch Controller

This block supervises one channel of a low-side power switch. It takes a channel control request, an enable shared by all channels, an awake line (low means standby) and two digitised fault flags from the analog front end: overcurrent and overtemperature. It produces the gate-enable for the output stage and a flag that says a fault has been latched.

A fault flag counts only once it has been present for longer than a qualification window. Then the latch sets, the gate drops in the same cycle and stays off even while the request stays high. The latch releases only when the control request has been low for longer than a suppression window. A short low pulse on the request does not restart the channel. Both windows are parameters in clock cycles. The three control lines pass through two-flop synchronisers. The fault flags are taken as already synchronous to the clock.

Top module: `lsw_fault_ctrl`

## Requirements
- R1: `gate_on` is 1 exactly when the synchronised `awake`, `en_all` and `ctl_in` are all 1 and no fault is latched; each control line passes two flops, so `gate_on` reflects the values present at the clock edge two edges earlier.
- R2: A fault flag that is 1 on QUAL_CYC+1 consecutive clock edges sets `fault_latched`; a flag that is 1 on QUAL_CYC or fewer consecutive edges leaves it unchanged.
- R3: When the latch sets, `gate_on` is 0 in that same cycle, and it stays 0 while the latch is held, even with `ctl_in` held at 1.
- R4: A latched fault clears when the synchronised `ctl_in` is 0 on CLR_CYC+1 consecutive edges and no fault qualifies on that edge.
- R5: A low pulse on `ctl_in` that reaches the synchronised request for CLR_CYC or fewer edges does not clear the latch.
- R6: Overcurrent and overtemperature are qualified by separate counters with the same window, and either one can set the latch. Flags that alternate between the two never add up to one qualified fault.
- R7: While the synchronised `awake` is 0, the latch and every counter are held cleared and `gate_on` is 0.
- R8: A qualification counter restarts from zero whenever its flag is 0 on an edge, so two runs of QUAL_CYC edges split by one low edge do not latch.
- R9: If a fault qualifies on the same edge on which the release condition holds, the latch stays set.
- R10: While `rst_n` is 0 (synchronous, active low), both outputs are 0 and all state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_in | input | 1 | Channel on request, asynchronous |
| en_all | input | 1 | Enable shared by all channels, asynchronous |
| awake | input | 1 | 0 = standby, 1 = active; asynchronous |
| oc_flag | input | 1 | Overcurrent flag, synchronous to clk |
| ot_flag | input | 1 | Overtemperature flag, synchronous to clk |
| gate_on | output | 1 | Gate enable for the output stage |
| fault_latched | output | 1 | A qualified fault is latched |

## Verification
The assertions check several rules on every cycle. A latch can only rise after a fault flag was present. A latch only falls after the request or the awake line was low. A latch holds while the request stays high. Standby leaves nothing latched, a qualified fault wins over a release, and the qualification counters return to zero after a low flag. The exact window lengths need the bench scenarios. These are the QUAL_CYC versus QUAL_CYC+1 fault runs, the CLR_CYC low pulse that must not release, alternating overcurrent and overtemperature flags, and a persisting fault held through a long low request. Random traffic compared cycle by cycle against the bench's reference model covers the mixed sequences.

// File: rtl/lsw_pkg.sv
// Shared definitions for the low-side switch fault controller.
// Assumes exactly two fault sources, packed as {overtemp, overcurrent}.
package lsw_pkg;

    localparam int unsigned NUM_FAULTS = 2;

    // Bit positions inside the fault vector
    localparam int unsigned FLT_OC = 0;
    localparam int unsigned FLT_OT = 1;

    // Control lines carried together through the synchroniser
    typedef struct packed {
        logic ctl;
        logic en;
        logic awake;
    } ctl_bus_t;

endpackage

// File: rtl/lsw_sync.sv
// Two-flop synchroniser for a bundle of slow asynchronous control lines.
// Assumes each bit is independent; no multi-bit coherency is needed.
module lsw_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    // First and second stage, both cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/lsw_persist.sv
// Persistence detector: raises 'done' on the edge where 'level' has been
// high for HOLD_CYC+1 consecutive edges (and every later high edge).
// Used both for fault qualification and for the release low-time.
// Assumes HOLD_CYC >= 1.
module lsw_persist #(
    parameter int unsigned HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic level,
    output logic done
);

    localparam int unsigned CW    = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

    logic [CW-1:0] cnt;

    // Window complete when the level is still high at the saturated count
    assign done = level && (cnt == LIMIT);

    // Saturating run-length counter; any low edge restarts it
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (!level) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);                                             // R2
    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(level) |-> cnt == '0);                              // R8

endmodule

// File: rtl/lsw_latch.sv
// Fault latch with set priority over release and a synchronous clear.
// Assumes 'set' and 'release_ok' come from registered qualifiers.
module lsw_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all,
    input  logic set,
    input  logic release_ok,
    output logic latched
);

    // Hold, set (wins) or release the fault state
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            latched <= 1'b0;
        end else if (set) begin
            latched <= 1'b1;
        end else if (release_ok) begin
            latched <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set && !clr_all |=> latched);                              // R9
    AST_HOLD_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(latched) && !$past(release_ok) && !$past(clr_all) |-> latched); // R5

endmodule

// File: rtl/lsw_fault_ctrl.sv
// Per-channel protection controller for a low-side switch.
// Synchronises the control lines, qualifies each fault flag by duration,
// latches qualified faults, gates the output and releases the latch after
// a long enough low time on the request. Fault flags must be synchronous.
module lsw_fault_ctrl
    import lsw_pkg::*;
#(
    parameter int unsigned QUAL_CYC = 6000,
    parameter int unsigned CLR_CYC  = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_in,
    input  logic en_all,
    input  logic awake,
    input  logic oc_flag,
    input  logic ot_flag,
    output logic gate_on,
    output logic fault_latched
);

    ctl_bus_t              raw_bus;
    ctl_bus_t              sync_bus;
    logic [CTL_W-1:0]      sync_vec;
    logic [NUM_FAULTS-1:0] faults;
    logic [NUM_FAULTS-1:0] hits;
    logic                  standby;
    logic                  release_ok;

    localparam int unsigned CTL_W = $bits(ctl_bus_t);

    // Bundle the asynchronous control lines
    assign raw_bus = '{ctl: ctl_in, en: en_all, awake: awake};

    lsw_sync #(.WIDTH(CTL_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_vec)
    );
    assign sync_bus = ctl_bus_t'(sync_vec);
    assign standby  = !sync_bus.awake;

    // Fault vector in package bit order
    assign faults[FLT_OC] = oc_flag;
    assign faults[FLT_OT] = ot_flag;

    // One qualification window per fault source
    for (genvar gi = 0; gi < NUM_FAULTS; gi++) begin : g_qual
        lsw_persist #(.HOLD_CYC(QUAL_CYC)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (standby),
            .level (faults[gi]),
            .done  (hits[gi])
        );
    end

    // Low-time window on the synchronised request
    lsw_persist #(.HOLD_CYC(CLR_CYC)) u_release (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (standby),
        .level (!sync_bus.ctl),
        .done  (release_ok)
    );

    lsw_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (standby),
        .set        (|hits),
        .release_ok (release_ok),
        .latched    (fault_latched)
    );

    // Gate drive: all qualifiers true and nothing latched
    assign gate_on = sync_bus.awake && sync_bus.en && sync_bus.ctl && !fault_latched;

    AST_RISE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_latched) |-> $past(oc_flag || ot_flag));       // R2
    AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_latched) |-> (!$past(sync_bus.ctl) || !$past(sync_bus.awake))); // R4
    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_latched && sync_bus.ctl && sync_bus.awake) |-> fault_latched); // R3
    AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_bus.awake) |-> !fault_latched);                // R7

endmodule

// File: tb/lsw_fault_ctrl_test.sv
// Bench: directed corner cases plus seeded random traffic, compared every
// cycle with a reference model written from the requirements.
module lsw_fault_ctrl_test;

    localparam int Q = 5;
    localparam int C = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ci = 1'b0, en = 1'b0, sb = 1'b0, oc = 1'b0, ot = 1'b0;
    logic gate, flt;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // reference state: {ctl,en,awake} after stage 1 and 2
    bit [2:0] m_s1, m_s2;
    int       m_q [2];
    int       m_l;
    bit       m_lat;

    always #4 clk = ~clk;

    lsw_fault_ctrl #(.QUAL_CYC(Q), .CLR_CYC(C)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_in(ci), .en_all(en), .awake(sb),
        .oc_flag(oc), .ot_flag(ot), .gate_on(gate), .fault_latched(flt)
    );

    function automatic void model_edge();
        bit fl [2];
        bit setf = 1'b0;
        bit clr;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_q[0] = 0; m_q[1] = 0; m_l = 0; m_lat = 1'b0;
            return;
        end
        if (!m_s2[0]) begin
            m_lat = 1'b0; m_q[0] = 0; m_q[1] = 0; m_l = 0;
        end else begin
            fl[0] = oc; fl[1] = ot;
            for (int i = 0; i < 2; i++) begin
                if (fl[i] && m_q[i] == Q) setf = 1'b1;
                m_q[i] = fl[i] ? ((m_q[i] < Q) ? m_q[i] + 1 : Q) : 0;
            end
            clr = !m_s2[2] && (m_l == C);
            m_l = !m_s2[2] ? ((m_l < C) ? m_l + 1 : C) : 0;
            if (setf) m_lat = 1'b1;
            else if (clr) m_lat = 1'b0;
        end
        m_s2 = m_s1;
        m_s1 = {ci, en, sb};
    endfunction

    function automatic bit exp_gate();
        return m_s2[2] & m_s2[1] & m_s2[0] & !m_lat;
    endfunction

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: inputs already driven, model follows the edge, compare at negedge
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "gate_on vs model", gate, exp_gate());
        check(tag, "fault_latched vs model", flt, m_lat);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240731));
        @(negedge clk);
        // R10: reset state
        rst_n = 1'b0; sb = 1'b1; en = 1'b1; ci = 1'b1;
        run(3, "R10");
        check("R10", "gate in reset", gate, 1'b0);
        check("R10", "fault in reset", flt, 1'b0);
        rst_n = 1'b1;
        // R1: gating and two-edge latency
        step("R1");
        check("R1", "gate after 1 edge", gate, 1'b0);
        step("R1");
        check("R1", "gate after 2 edges", gate, 1'b1);
        en = 1'b0; run(3, "R1");
        check("R1", "gate with enable low", gate, 1'b0);
        en = 1'b1; run(3, "R1");
        // R2: boundary of the qualification window
        oc = 1'b1; run(Q, "R2"); oc = 1'b0; run(2, "R2");
        check("R2", "fault after Q edges", flt, 1'b0);
        oc = 1'b1; run(Q + 1, "R2");
        check("R2", "fault after Q+1 edges", flt, 1'b1);
        check("R3", "gate on latch edge", gate, 1'b0);
        oc = 1'b0; run(10, "R3");
        check("R3", "gate with request high", gate, 1'b0);
        check("R3", "latch held", flt, 1'b1);
        // R5: short low pulse
        ci = 1'b0; run(C, "R5"); ci = 1'b1; run(4, "R5");
        check("R5", "fault after short low", flt, 1'b1);
        check("R5", "gate after short low", gate, 1'b0);
        // R4: long low pulse releases
        ci = 1'b0; run(C + 3, "R4");
        check("R4", "fault after long low", flt, 1'b0);
        ci = 1'b1; run(3, "R4");
        check("R4", "gate restarts", gate, 1'b1);
        // R8: counter restart
        ot = 1'b1; run(Q, "R8"); ot = 1'b0; step("R8");
        ot = 1'b1; run(Q, "R8"); ot = 1'b0; run(2, "R8");
        check("R8", "split run no latch", flt, 1'b0);
        // R6: alternating sources never combine; each alone latches
        for (int i = 0; i < 20; i++) begin
            oc = i[0]; ot = !i[0]; step("R6");
        end
        oc = 1'b0; ot = 1'b0; run(2, "R6");
        check("R6", "alternating flags", flt, 1'b0);
        ot = 1'b1; run(Q + 1, "R6");
        check("R6", "overtemp latches", flt, 1'b1);
        ot = 1'b0;
        // R7: standby clears
        sb = 1'b0; run(3, "R7");
        check("R7", "fault in standby", flt, 1'b0);
        check("R7", "gate in standby", gate, 1'b0);
        sb = 1'b1; run(3, "R7");
        check("R7", "gate after wake", gate, 1'b1);
        // R9: persisting fault beats release
        ot = 1'b1; run(Q + 1, "R9");
        ci = 1'b0; run(C + 5, "R9");
        check("R9", "persisting fault held", flt, 1'b1);
        ot = 1'b0; run(2, "R9");
        check("R9", "release once fault gone", flt, 1'b0);
        ci = 1'b1; run(3, "R9");
        // random traffic, all requirements via model (R1..R9)
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 200 == 0) sb = ~sb;
            if ($urandom % 50 == 0)  en = ~en;
            if ($urandom % 12 == 0)  ci = ~ci;
            if ($urandom % 6 == 0)   oc = ~oc;
            if ($urandom % 8 == 0)   ot = ~ot;
            if (!sb && ($urandom % 4 == 0)) sb = 1'b1;
            step("R1");
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule